// File: doc/BRIEF.md
# Bit-Serial-Decision Streaming Median Filter

This block filters a one-dimensional stream of unsigned samples with a sliding median. Each accepted sample enters a window of the most recent `WIN` samples. For every window that is full, the block emits the median of that window. It produces one result per accepted sample and never sorts.

The median is resolved one bit per pipeline stage, starting at the most significant bit. There are `WIDTH` stages, one per bit of the sample word, whatever the window length.

Each stage does four things:
- It counts the ones in its bit column among the samples that are still candidates.
- It adds the number of samples already known to be larger than the median.
- It compares that total with the median rank and so decides one result bit.
- It drops every candidate whose bit disagrees with the decision.

The window, the candidate mask, the larger-than count and the partially built result then move on to the next stage. In that stage the upper result bits are already fixed. The interface is a plain valid-qualified stream with no backpressure: `in_vld` marks an accepted sample and `out_vld` marks a result.

Top module: `medf_top`

## Requirements
- R1: While `rst_n` is low, and in idle cycles after reset before any sample arrives, `out_vld` is 0.
- R2: No result is produced until `WIN` samples have been accepted. The first `WIN-1` accepted samples yield no result.
- R3: The window completed by a sample accepted at clock edge k yields its result at edge k+`WIDTH`, with `out_vld` high for that one cycle. With 8-bit data and a window of 9, the first result follows the first sample by 16 clocks. A back-to-back input stream yields one result per clock.
- R4: `out_med` equals the element of rank (`WIN`+1)/2 in ascending order of the last `WIN` accepted samples. All samples are treated as unsigned binary integers.
- R5: Windows that contain repeated values give the same rank-based result. After the final stage, every surviving candidate equals the result.
- R6: A cycle with `in_vld` low neither shifts the window nor produces a result. The result stream keeps the input's gaps, delayed by `WIDTH` cycles.
- R7: Extreme windows are exact: all zeros give 0, all ones give 2^`WIDTH`-1, and a mix of zeros and all-ones values gives the majority value.
- R8: The window 36, 76, 146, 36, 71, 152, 24, 66, 54 gives 66.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_vld | input | 1 | Sample on `in_data` is accepted this cycle |
| in_data | input | WIDTH | Unsigned input sample |
| out_vld | output | 1 | `out_med` holds a result this cycle |
| out_med | output | WIDTH | Median of the window |

## Verification
The bench builds the block with its defaults: 8-bit samples and a 9-sample window. At that size every value from 0 to 255 can appear, and a median rank of 5 lets duplicate-heavy windows, drawn from a four-value alphabet, land survivors in every stage. Each output cycle is compared against a sorted reference window kept by the bench. The checks cover back-to-back streams, streams with random gaps, and the all-zero and all-ones extremes. The worked window and the 16-clock first-result latency are also checked directly.

// File: rtl/medf_pkg.sv
package medf_pkg;

  // rank (1-based, ascending) of the median in an odd window
  function automatic int rank_of(input int n);
    return (n + 1) / 2;
  endfunction

  // bits needed to hold a count from 0 to n
  function automatic int cnt_bits(input int n);
    return $clog2(n + 1);
  endfunction

endpackage

// File: rtl/medf_popcnt.sv
module medf_popcnt #(
  parameter int N  = 9,
  parameter int CW = 4
) (
  input  logic [N-1:0]  bits_i,
  output logic [CW-1:0] cnt_o
);

  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < N; i++) begin
      cnt_o = cnt_o + CW'(bits_i[i]);
    end
  end

endmodule

// File: rtl/medf_window.sv
module medf_window #(
  parameter int WIDTH = 8,
  parameter int WIN   = 9
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_vld,
  input  logic [WIDTH-1:0]          in_data,
  output logic [WIN-1:0][WIDTH-1:0] win_o,
  output logic                      win_vld_o
);

  localparam int             CW   = medf_pkg::cnt_bits(WIN);
  localparam logic [CW-1:0]  FULL = CW'(WIN);
  localparam logic [CW-1:0]  LAST = CW'(WIN - 1);

  logic [WIN-1:0][WIDTH-1:0] win_q, win_d;
  logic [CW-1:0]             fill_q, fill_d;
  logic                      vld_q, vld_d;

  // next state: newest sample at index 0
  always_comb begin
    win_d    = win_q;
    win_d[0] = in_data;
    for (int i = 1; i < WIN; i++) begin
      win_d[i] = win_q[i-1];
    end
    fill_d = (in_vld && (fill_q != FULL)) ? fill_q + 1'b1 : fill_q;
    vld_d  = in_vld && (fill_q >= LAST);
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      fill_q <= fill_d;
      vld_q  <= vld_d;
    end
  end

  // datapath registers, enabled by accepted samples
  always_ff @(posedge clk) begin
    if (in_vld) begin
      win_q <= win_d;
    end
  end

  assign win_o     = win_q;
  assign win_vld_o = vld_q;

endmodule

// File: rtl/medf_slice.sv
module medf_slice #(
  parameter int WIDTH  = 8,
  parameter int WIN    = 9,
  parameter int BITPOS = 7
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     vld_i,
  input  logic [WIN-1:0][WIDTH-1:0]                win_i,
  input  logic [WIN-1:0]                           mask_i,
  input  logic [medf_pkg::cnt_bits(WIN)-1:0]       rej_i,
  input  logic [WIDTH-1:0]                         part_i,
  output logic                                     vld_o,
  output logic [WIN-1:0][WIDTH-1:0]                win_o,
  output logic [WIN-1:0]                           mask_o,
  output logic [medf_pkg::cnt_bits(WIN)-1:0]       rej_o,
  output logic [WIDTH-1:0]                         part_o
);

  localparam int            CW   = medf_pkg::cnt_bits(WIN);
  localparam int            MED  = medf_pkg::rank_of(WIN);
  localparam logic [CW:0]   MEDV = (CW + 1)'(MED);

  logic [WIN-1:0]   col, live_ones, mask_d;
  logic [CW-1:0]    ones_cnt, rej_d;
  logic [CW:0]      ge_cnt;
  logic             mbit;
  logic [WIDTH-1:0] part_d;

  always_comb begin
    for (int i = 0; i < WIN; i++) begin
      col[i] = win_i[i][BITPOS];
    end
    live_ones = col & mask_i;
  end

  medf_popcnt #(.N(WIN), .CW(CW)) u_cnt (
    .bits_i (live_ones),
    .cnt_o  (ones_cnt)
  );

  // decision and next-state for the following stage
  always_comb begin
    ge_cnt         = {1'b0, rej_i} + {1'b0, ones_cnt};
    mbit           = (ge_cnt >= MEDV);
    mask_d         = mask_i & ~(col ^ {WIN{mbit}});
    rej_d          = mbit ? rej_i : rej_i + ones_cnt;
    part_d         = part_i;
    part_d[BITPOS] = mbit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o <= 1'b0;
    end else begin
      vld_o <= vld_i;
    end
  end

  always_ff @(posedge clk) begin
    if (vld_i) begin
      win_o  <= win_i;
      mask_o <= mask_d;
      rej_o  <= rej_d;
      part_o <= part_d;
    end
  end

endmodule

// File: rtl/medf_top.sv
module medf_top #(
  parameter int WIDTH = 8,
  parameter int WIN   = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  input  logic [WIDTH-1:0] in_data,
  output logic             out_vld,
  output logic [WIDTH-1:0] out_med
);

  localparam int CW = medf_pkg::cnt_bits(WIN);

  // stage k input at index k; index WIDTH is the final register
  logic                      s_vld  [WIDTH+1];
  logic [WIN-1:0][WIDTH-1:0] s_win  [WIDTH+1];
  logic [WIN-1:0]            s_mask [WIDTH+1];
  logic [CW-1:0]             s_rej  [WIDTH+1];
  logic [WIDTH-1:0]          s_part [WIDTH+1];

  medf_window #(.WIDTH(WIDTH), .WIN(WIN)) u_win (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_vld    (in_vld),
    .in_data   (in_data),
    .win_o     (s_win[0]),
    .win_vld_o (s_vld[0])
  );

  assign s_mask[0] = '1;
  assign s_rej[0]  = '0;
  assign s_part[0] = '0;

  for (genvar g = 0; g < WIDTH; g++) begin : g_stage
    medf_slice #(.WIDTH(WIDTH), .WIN(WIN), .BITPOS(WIDTH - 1 - g)) u_slice (
      .clk    (clk),
      .rst_n  (rst_n),
      .vld_i  (s_vld[g]),
      .win_i  (s_win[g]),
      .mask_i (s_mask[g]),
      .rej_i  (s_rej[g]),
      .part_i (s_part[g]),
      .vld_o  (s_vld[g+1]),
      .win_o  (s_win[g+1]),
      .mask_o (s_mask[g+1]),
      .rej_o  (s_rej[g+1]),
      .part_o (s_part[g+1])
    );
  end

  assign out_vld = s_vld[WIDTH];
  assign out_med = s_part[WIDTH];

endmodule

// File: rtl/medf_chk.sv
module medf_chk #(
  parameter int WIDTH = 8,
  parameter int WIN   = 9
) (
  input logic                                clk,
  input logic                                rst_n,
  input logic                                in_vld,
  input logic                                out_vld,
  input logic [WIDTH-1:0]                    out_med,
  input logic [WIN-1:0][WIDTH-1:0]           fin_win,
  input logic                                c_vld  [1:WIDTH],
  input logic [WIN-1:0]                      c_mask [1:WIDTH],
  input logic [medf_pkg::cnt_bits(WIN)-1:0]  c_rej  [1:WIDTH],
  input logic [WIDTH-1:0]                    c_part [1:WIDTH]
);

  localparam int MED = medf_pkg::rank_of(WIN);
  localparam int CW  = medf_pkg::cnt_bits(WIN);

  logic [CW:0] seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= '0;
    end else if (in_vld && (seen_q < (CW + 1)'(WIN))) begin
      seen_q <= seen_q + 1'b1;
    end
  end

  int   gt_n, ge_n;
  logic surv_ok;
  always_comb begin
    gt_n    = 0;
    ge_n    = 0;
    surv_ok = (c_mask[WIDTH] != '0);
    for (int i = 0; i < WIN; i++) begin
      if (fin_win[i] > out_med)  gt_n++;
      if (fin_win[i] >= out_med) ge_n++;
      if (c_mask[WIDTH][i] && (fin_win[i] != out_med)) surv_ok = 1'b0;
    end
  end

  // R2
  fill_before_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> (seen_q >= (CW + 1)'(WIN)));

  // R4
  rank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> ((gt_n < MED) && (ge_n >= MED)));

  // R5
  survivor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> surv_ok);

  for (genvar g = 1; g <= WIDTH; g++) begin : g_rej
    // R4
    rej_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      c_vld[g] |-> (int'(c_rej[g]) < MED));
  end

  for (genvar g = 1; g < WIDTH; g++) begin : g_pipe
    // R4
    mask_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
      c_vld[g+1] |-> ((c_mask[g+1] & ~$past(c_mask[g])) == '0));
    // R4
    upper_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      c_vld[g+1] |-> (c_part[g+1][WIDTH-1 -: g] == $past(c_part[g][WIDTH-1 -: g])));
  end

endmodule

bind medf_top medf_chk #(.WIDTH(WIDTH), .WIN(WIN)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .in_vld  (in_vld),
  .out_vld (out_vld),
  .out_med (out_med),
  .fin_win (s_win[WIDTH]),
  .c_vld   (s_vld[1:WIDTH]),
  .c_mask  (s_mask[1:WIDTH]),
  .c_rej   (s_rej[1:WIDTH]),
  .c_part  (s_part[1:WIDTH])
);

// File: tb/tb_medf_top.sv
module tb_medf_top;

  localparam int WIDTH = 8;
  localparam int WIN   = 9;
  localparam int MED   = (WIN + 1) / 2;
  localparam int CLK_P = 10;
  localparam int MAXE  = 16384;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_vld = 1'b0;
  logic [WIDTH-1:0] in_data = '0;
  logic             out_vld;
  logic [WIDTH-1:0] out_med;

  always #(CLK_P/2) clk = ~clk;

  medf_top #(.WIDTH(WIDTH), .WIN(WIN)) dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_vld  (in_vld),
    .in_data (in_data),
    .out_vld (out_vld),
    .out_med (out_med)
  );

  int    n_run = 0;
  int    n_fail = 0;
  int    e = 0;
  bit    exp_v [MAXE];
  int    exp_d [MAXE];
  int    hist  [WIN];
  int    seen = 0;
  string tag = "R1";
  int    first_out = -1;
  int    first_val = -1;

  task automatic chk(input bit ok, input string t, input int act, input int xp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", t, act, xp);
    end
  endtask

  function automatic int ref_med();
    int s [WIN];
    int t;
    for (int i = 0; i < WIN; i++) s[i] = hist[i];
    for (int i = 1; i < WIN; i++) begin
      for (int j = i; j > 0; j--) begin
        if (s[j-1] > s[j]) begin
          t = s[j]; s[j] = s[j-1]; s[j-1] = t;
        end
      end
    end
    return s[MED-1];
  endfunction

  // drive inputs for the next edge, then check outputs after it
  task automatic step(input bit v, input int d);
    in_vld  = v;
    in_data = d[WIDTH-1:0];
    if (v) begin
      for (int i = WIN - 1; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = d;
      if (seen < WIN) seen++;
      if (seen == WIN) begin
        exp_v[e + 1 + WIDTH] = 1'b1;
        exp_d[e + 1 + WIDTH] = ref_med();
      end
    end
    @(negedge clk);
    e++;
    chk(out_vld == exp_v[e], {tag, " out_vld"}, int'(out_vld), int'(exp_v[e]));
    if (exp_v[e] && out_vld)
      chk(int'(out_med) == exp_d[e], {tag, " out_med"}, int'(out_med), exp_d[e]);
    if (out_vld && first_out < 0) begin
      first_out = e;
      first_val = int'(out_med);
    end
  endtask

  task automatic flush();
    for (int i = 0; i < WIDTH + 2; i++) step(1'b0, 0);
  endtask

  initial begin
    int demo [WIN] = '{36, 76, 146, 36, 71, 152, 24, 66, 54};
    int alpha [4] = '{0, 7, 8, 255};

    // R1: reset held, then idle
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(out_vld == 1'b0, "R1 out_vld in reset", int'(out_vld), 0);
    end
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) step(1'b0, 0);

    // R2 / R8: worked window, first result timing
    tag = "R2";
    for (int i = 0; i < WIN; i++) step(1'b1, demo[i]);
    tag = "R8";
    flush();
    // R3: first sample at edge 4, result WIN-1+WIDTH edges later
    chk(first_out == 4 + WIN - 1 + WIDTH, "R3 first result edge", first_out, 4 + WIN - 1 + WIDTH);
    chk(first_val == 66, "R8 worked window", first_val, 66);

    // R3: back-to-back stream
    tag = "R3";
    for (int i = 0; i < 300; i++) step(1'b1, $urandom_range(0, 255));
    flush();

    // R4: long random stream
    tag = "R4";
    for (int i = 0; i < 3000; i++) step(1'b1, $urandom_range(0, 255));

    // R5: duplicate-heavy stream
    tag = "R5";
    for (int i = 0; i < 2000; i++) step(1'b1, alpha[$urandom_range(0, 3)]);

    // R6: random gaps
    tag = "R6";
    for (int i = 0; i < 2000; i++) step(($urandom_range(0, 2) != 0), $urandom_range(0, 255));
    flush();

    // R7: extremes
    tag = "R7";
    for (int i = 0; i < 40; i++) step(1'b1, 0);
    for (int i = 0; i < 40; i++) step(1'b1, 255);
    for (int i = 0; i < 60; i++) step(1'b1, ((i % 3) == 0) ? 0 : 255);
    for (int i = 0; i < 60; i++) step(1'b1, ((i % 3) == 0) ? 255 : 0);
    flush();

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    n_fail++;
    $display("FAIL R3 watchdog expired actual=%0d expected=%0d", e, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule